// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is the output stage that sits behind one OR gate of a programmable sum-of-products array. It takes the OR-gate result (the sum term) and produces three things: the value for the output pad, the pad's output enable, and a feedback bit that goes back into the AND array. A D flip-flop inside the cell can be placed in the output path or left out of it. The output can be inverted. The flip-flop can be clocked from either of two clock inputs. The feedback can come from the flip-flop or from the pin.

Four static configuration inputs choose among these options. An unprogrammed configuration bit reads as 1. The bypass bit sets the default feedback source, and a fourth bit can invert that choice. This makes the feedback source independent of the output mode, so the cell offers eight output configurations in all.

The bidirectional pin is modelled as three separate signals: the value driven out, the enable for that driver, and the value seen on the pin. The cell also has an asynchronous clear, a synchronous preset and an output-enable product term.

Top module: `pal_macrocell`

## Requirements
- R1: When all four configuration inputs are 1, the cell is combinational and active high, its feedback comes from the pin, and its flip-flop is clocked by `clk_a`.
- R2: When `cfg_pol` is 1, `pad_out` carries the selected value unchanged. When `cfg_pol` is 0, `pad_out` carries the inverse of the selected value.
- R3: When `cfg_bypass` is 1, the selected value is `sum_term` combinationally. When `cfg_bypass` is 0, the selected value is the flip-flop state.
- R4: When `cfg_clk_sel` is 1, the flip-flop is clocked by `clk_a`. When `cfg_clk_sel` is 0, it is clocked by `clk_b`. Edges of the clock that is not selected have no effect on the flip-flop.
- R5: On each rising edge of the selected clock, the flip-flop loads `sum_term`, provided that `preset` is low and `arst` is low.
- R6: When `cfg_fb_follow` is 1, `fb_out` is the flip-flop state if `cfg_bypass` is 0 and `pad_in` if `cfg_bypass` is 1. When `cfg_fb_follow` is 0, these two choices are swapped.
- R7: While `arst` is high, the flip-flop is 0. The clear takes effect at once, without waiting for any clock edge.
- R8: When `preset` is high at a rising edge of the selected clock, the flip-flop becomes 1 whatever `sum_term` is. `arst` takes priority over `preset`.
- R9: `pad_oe` follows `oe_term`. When `pad_oe` is low, pin feedback carries the externally driven `pad_in` value.
- R10: Register feedback carries the true flip-flop state, whatever the setting of `cfg_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First clock candidate |
| clk_b | input | 1 | Second clock candidate |
| arst | input | 1 | Asynchronous clear of the flip-flop, active high |
| cfg_pol | input | 1 | Output polarity: 1 = active high, 0 = active low |
| cfg_bypass | input | 1 | 1 = combinational output, 0 = registered output |
| cfg_clk_sel | input | 1 | 1 = clock from `clk_a`, 0 = clock from `clk_b` |
| cfg_fb_follow | input | 1 | 1 = feedback follows the bypass bit, 0 = the feedback choice is inverted |
| sum_term | input | 1 | Sum term from the OR gate |
| preset | input | 1 | Synchronous set of the flip-flop |
| oe_term | input | 1 | Output-enable product term |
| pad_in | input | 1 | Value observed on the pin |
| pad_out | output | 1 | Value driven toward the pin |
| pad_oe | output | 1 | Enable for the pin driver |
| fb_out | output | 1 | Feedback bit to the AND array |

## Verification
The bench steps through all sixteen configuration codes with a mix of sum-term, preset, output-enable and external-pin stimulus. This exposes a design that ties the feedback source to the bypass bit alone: with `cfg_fb_follow` at 0, such a design returns the pin where the register is expected. The two clocks are given periods whose rising edges never coincide, so a multiplexer wired the wrong way round produces captures on the wrong edges. A clear asserted in the middle of a cycle is checked before the next edge, which catches a clear that waits for a clock. Checks made with `cfg_pol` at 0 while register feedback is selected catch a design that takes its feedback after the output inverter.

// File: rtl/pal_macrocell.sv
module pal_macrocell (
  input  logic clk_a,
  input  logic clk_b,
  input  logic arst,
  input  logic cfg_pol,
  input  logic cfg_bypass,
  input  logic cfg_clk_sel,
  input  logic cfg_fb_follow,
  input  logic sum_term,
  input  logic preset,
  input  logic oe_term,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic fb_out
);

  logic reg_clk;
  logic q;
  logic past_ok;
  logic sel_val;
  logic pin_fb;

  assign reg_clk = cfg_clk_sel ? clk_a : clk_b;

  always_ff @(posedge reg_clk or posedge arst) begin
    if (arst) begin
      q       <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      q       <= preset | sum_term;
      past_ok <= 1'b1;
    end
  end

  assign sel_val = cfg_bypass ? sum_term : q;
  assign pad_out = cfg_pol ? sel_val : ~sel_val;
  assign pad_oe  = oe_term;
  assign pin_fb  = cfg_fb_follow ? cfg_bypass : ~cfg_bypass;
  assign fb_out  = pin_fb ? pad_in : q;

  AST_CAPTURE: assert property (@(posedge reg_clk) disable iff (arst)
    (past_ok && !$past(preset)) |-> (q == $past(sum_term))); // R5

  AST_PRESET_SET: assert property (@(posedge reg_clk) disable iff (arst)
    (past_ok && $past(preset)) |-> q); // R8

  AST_COMB_PATH: assert property (@(posedge clk_a) disable iff (arst)
    cfg_bypass |-> (pad_out == (sum_term ^ ~cfg_pol))); // R3

  AST_FB_REG: assert property (@(posedge clk_a) disable iff (arst)
    (cfg_bypass ^ cfg_fb_follow) |-> (fb_out == q)); // R6

  AST_FB_PIN: assert property (@(posedge clk_a) disable iff (arst)
    !(cfg_bypass ^ cfg_fb_follow) |-> (fb_out == pad_in)); // R9

endmodule

// File: tb/sim_pal_macrocell.sv
module sim_pal_macrocell;
  logic clk_a = 1'b0, clk_b = 1'b0, arst = 1'b1;
  logic cfg_pol = 1'b1, cfg_bypass = 1'b1, cfg_clk_sel = 1'b1, cfg_fb_follow = 1'b1;
  logic sum_term = 1'b0, preset = 1'b0, oe_term = 1'b0, ext_val = 1'b0;
  logic pad_in, pad_out, pad_oe, fb_out;
  logic m_q = 1'b0;
  int errs = 0, checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign pad_in = pad_oe ? pad_out : ext_val;

  pal_macrocell u0 (
    .clk_a(clk_a), .clk_b(clk_b), .arst(arst),
    .cfg_pol(cfg_pol), .cfg_bypass(cfg_bypass), .cfg_clk_sel(cfg_clk_sel),
    .cfg_fb_follow(cfg_fb_follow), .sum_term(sum_term), .preset(preset),
    .oe_term(oe_term), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_out(fb_out)
  );

  always #5 clk_a = ~clk_a;
  initial begin
    #2;
    forever begin clk_b = 1'b1; #7; clk_b = 1'b0; #7; end
  end

  always @(posedge clk_a) if (cfg_clk_sel && !arst) m_q = preset ? 1'b1 : sum_term;
  always @(posedge clk_b) if (!cfg_clk_sel && !arst) m_q = preset ? 1'b1 : sum_term;
  always @(posedge arst) m_q = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_out();
    logic v;
    v = cfg_bypass ? sum_term : m_q;
    return cfg_pol ? v : ~v;
  endfunction

  function automatic logic exp_fb();
    logic use_pin;
    use_pin = cfg_fb_follow ? cfg_bypass : !cfg_bypass;
    if (!use_pin) return m_q;
    return oe_term ? exp_out() : ext_val;
  endfunction

  task automatic compare_all(input string extra);
    chk({extra, " R2 R3 R4 R5 R8 pad_out"}, pad_out, exp_out());
    chk({extra, " R9 pad_oe"}, pad_oe, oe_term);
    chk({extra, " R6 R9 R10 fb_out"}, fb_out, exp_fb());
  endtask

  task automatic step(input logic s, input logic p, input logic oe, input logic ev, input string extra);
    @(negedge clk_a);
    #1;
    sum_term = s; preset = p; oe_term = oe; ext_val = ev;
    #7;
    compare_all(extra);
  endtask

  task automatic set_cfg(input logic [3:0] c);
    @(negedge clk_a);
    #1 arst = 1'b1;
    {cfg_fb_follow, cfg_clk_sel, cfg_bypass, cfg_pol} = c;
    @(negedge clk_a);
    #1 arst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // reset state with default configuration
    #9;
    chk("R7 reset fb_out", fb_out, 1'b0);
    chk("R9 reset pad_oe", pad_oe, 1'b0);
    @(negedge clk_a);
    #1 arst = 1'b0;
    // R1: default all-ones configuration is combinational, active high, pin feedback
    step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    chk("R1 comb high", pad_out, 1'b1);
    chk("R1 pin fb", fb_out, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
    chk("R1 pin fb external", fb_out, 1'b1);
    chk("R1 comb low", pad_out, 1'b0);

    // sweep every configuration code
    for (int c = 0; c < 16; c++) begin
      set_cfg(c[3:0]);
      for (int k = 0; k < 40; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0], lfsr[3] & lfsr[5], lfsr[7] | lfsr[9], lfsr[11], "sweep");
      end
    end

    // R7: clear takes effect between clock edges (registered, reg feedback, active low)
    set_cfg(4'b1100);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7 load");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7 load");
    chk("R10 true state with inverted pad", fb_out, 1'b1);
    chk("R2 inverted pad", pad_out, 1'b0);
    @(negedge clk_a);
    #1 arst = 1'b1;
    #1;
    chk("R7 immediate clear fb", fb_out, 1'b0);
    chk("R7 immediate clear pad", pad_out, 1'b1);
    // R8: preset under active clear has no effect
    preset = 1'b1;
    @(negedge clk_a);
    #1;
    chk("R8 clear dominates preset", fb_out, 1'b0);
    arst = 1'b0;
    // R8: preset wins over a zero sum term
    step(1'b0, 1'b1, 1'b1, 1'b0, "R8");
    chk("R8 preset sets", fb_out, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    chk("R5 loads zero", fb_out, 1'b0);

    // R4: second clock selected, captures only on clk_b edges
    set_cfg(4'b1000);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4 clk_b capture", fb_out, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule